// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog counter that advances on its own free-running tick strobe rather than on processor activity. It shares one 8-stage binary prescaler with a general-purpose timer. A single assignment bit decides where the prescaler sits. With the bit set, the prescaler follows the watchdog as a postscaler and stretches the timeout. With the bit clear, the prescaler sits in front of the timer and divides the timer's clock source. A 3-bit rate field picks the prescaler tap.

Both kinds of tick arrive as one-cycle enable strobes on the always-on block clock. The watchdog therefore keeps counting while the processor's own clock is stopped during sleep. That gating sits outside this block.

The watchdog counts a fixed number of base ticks, set by a parameter. When it expires while the core runs, the block raises a one-cycle reset request. When it expires while the core sleeps, the block raises a one-cycle wake-up request instead. In both cases it drops an active-low timeout flag. The clear-watchdog and enter-sleep strobes restart the count. The block has no data stream, so every pin is a plain control or status signal and none carries back-pressure.

Top module: `wdt_shared_prescaler`

## Requirements
- R1: After reset, rst_req and wake_req are 0, to_n is 1 and tmr_tick is 0.
- R2: With psa=0 and wdt_en=1, the BASE_TICKS-th wdt_tick strobe after a clear raises a timeout. The timeout shows in the cycle after that strobe. While asleep=0, it is a single-cycle pulse on rst_req.
- R3: With psa=1, rate field value n makes the timeout occur on the (BASE_TICKS·2^n)-th wdt_tick after a clear. Value 0 gives 1:1 and value 7 gives 1:128.
- R4: A timeout while asleep=1 pulses wake_req for one cycle, and rst_req stays 0.
- R5: A timeout drives to_n to 0. A clrwdt or sleep_enter strobe sets it back to 1 in the next cycle.
- R6: A clrwdt or sleep_enter strobe restarts the watchdog count. When psa=1, it also zeroes the prescaler. A strobe that coincides with a wdt_tick wins, and no timeout results from that tick.
- R7: While wdt_en=0, the watchdog never times out, whatever wdt_tick does.
- R8: With psa=0, tmr_tick pulses once for every 2^(n+1) tmr_src strobes, where n is the rate field. Counting starts from reset, and the pulse follows the strobe that completes the group by one cycle.
- R9: With psa=1, each tmr_src strobe produces a tmr_tick pulse in the next cycle, and the prescaler plays no part.
- R10: Without a clear, the watchdog wraps after a timeout and times out again after another full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Power-on reset, active low |
| wdt_tick | input | 1 | One-cycle strobe from the watchdog's own oscillator |
| tmr_src | input | 1 | One-cycle strobe from the timer's clock source |
| wdt_en | input | 1 | Configuration bit; 0 disables the watchdog |
| psa | input | 1 | Prescaler assignment: 1 = watchdog postscaler, 0 = timer prescaler |
| ps | input | 3 | Rate field selecting the prescaler tap |
| clrwdt | input | 1 | Clear-watchdog instruction strobe |
| sleep_enter | input | 1 | Enter-sleep instruction strobe |
| asleep | input | 1 | Core is in sleep mode |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_n | output | 1 | Timeout status flag, active low |
| tmr_tick | output | 1 | Prescaled tick towards the timer |

## Verification
The properties rest on three assumptions about the inputs:
- All inputs are synchronous to clk.
- The clear strobes last one cycle.
- BASE_TICKS is at least 2, so two timeouts can never fall in adjacent cycles.

The pass-through property for the timer also assumes that psa is held steady around each tmr_src strobe. The bench keeps within these limits. It drives every input on the falling edge and holds each strobe for exactly one cycle. It leaves an idle cycle after each tick and changes psa and ps only while no strobe is in flight.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_RESET = 2'd1,
    EV_WAKE  = 2'd2
  } wdt_event_e;
endpackage

// File: rtl/wdt_base_counter.sv
module wdt_base_counter #(
  parameter int BASE_TICKS = 4096,
  parameter int CNT_W      = $clog2(BASE_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic clear,
  output logic ovf
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  // one wrap of the base period; a clear in the same cycle suppresses it
  assign ovf = enable && !clear && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!enable || clear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int STAGES = 8,
  parameter int SEL_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_pulse,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_hit
);
  localparam int TAPS = 2 ** SEL_W;

  logic [STAGES-1:0] cnt;
  logic [TAPS-1:0]   tap_ok;

  // tap k fires when the low k stages are all ones: divide by 2^k
  genvar k;
  generate
    for (k = 0; k < TAPS; k++) begin : g_tap
      if (k == 0) begin : g_pass
        assign tap_ok[k] = 1'b1;
      end else if (k <= STAGES) begin : g_stage
        assign tap_ok[k] = &cnt[k-1:0];
      end else begin : g_none
        assign tap_ok[k] = 1'b0;
      end
    end
  endgenerate

  assign tap_hit = in_pulse && tap_ok[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (in_pulse) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_event_gen.sv
module wdt_event_gen
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic asleep,
  input  logic restore,
  output logic rst_req,
  output logic wake_req,
  output logic to_n
);
  wdt_event_e kind;

  always_comb begin
    if (!expire)     kind = EV_NONE;
    else if (asleep) kind = EV_WAKE;
    else             kind = EV_RESET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_n     <= 1'b1;
    end else begin
      rst_req  <= (kind == EV_RESET);
      wake_req <= (kind == EV_WAKE);
      if (restore)     to_n <= 1'b1;
      else if (expire) to_n <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_shared_prescaler.sv
module wdt_shared_prescaler #(
  parameter int BASE_TICKS = 4096,
  parameter int PRE_STAGES = 8,
  parameter int RATE_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_tick,
  input  logic              tmr_src,
  input  logic              wdt_en,
  input  logic              psa,
  input  logic [RATE_W-1:0] ps,
  input  logic              clrwdt,
  input  logic              sleep_enter,
  input  logic              asleep,
  output logic              rst_req,
  output logic              wake_req,
  output logic              to_n,
  output logic              tmr_tick
);
  localparam int CNT_W = (BASE_TICKS > 1) ? $clog2(BASE_TICKS) : 1;
  localparam int SEL_W = RATE_W + 1;

  logic             clr;
  logic             base_ovf;
  logic             pre_in;
  logic             pre_clear;
  logic             pre_hit;
  logic [SEL_W-1:0] sel;
  logic             expire;

  assign clr = clrwdt || sleep_enter;

  wdt_base_counter #(
    .BASE_TICKS(BASE_TICKS),
    .CNT_W     (CNT_W)
  ) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (wdt_tick),
    .enable(wdt_en),
    .clear (clr),
    .ovf   (base_ovf)
  );

  // the shared stage chain: fed by watchdog wraps or by the timer source
  assign pre_in    = psa ? base_ovf : tmr_src;
  assign pre_clear = psa && clr;
  assign sel       = psa ? {1'b0, ps} : ({1'b0, ps} + 1'b1);

  wdt_prescaler #(
    .STAGES(PRE_STAGES),
    .SEL_W (SEL_W)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_pulse(pre_in),
    .clear   (pre_clear),
    .sel     (sel),
    .tap_hit (pre_hit)
  );

  assign expire = psa ? pre_hit : base_ovf;

  wdt_event_gen u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .asleep  (asleep),
    .restore (clr),
    .rst_req (rst_req),
    .wake_req(wake_req),
    .to_n    (to_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_tick <= 1'b0;
    else        tmr_tick <= psa ? tmr_src : pre_hit;
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic clk,
  input logic rst_n,
  input logic tmr_src,
  input logic wdt_en,
  input logic psa,
  input logic clrwdt,
  input logic sleep_enter,
  input logic asleep,
  input logic rst_req,
  input logic wake_req,
  input logic to_n,
  input logic tmr_tick
);
  // R2: a reset request lasts a single cycle
  a_r2_reset_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R4: the wake request lasts a single cycle and never joins a reset request
  a_r4_wake_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  a_r4_exclusive_events: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req));
  a_r4_wake_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(asleep));
  a_r2_reset_only_awake: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(asleep));

  // R5: the flag drops only with a timeout event
  a_r5_flag_falls_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(to_n) |-> (rst_req || wake_req));

  // R6: a clear strobe blocks any timeout and restores the flag
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clrwdt || sleep_enter) |=> (to_n && !rst_req && !wake_req));

  // R7: a disabled watchdog raises nothing
  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> (!rst_req && !wake_req));

  // R9: timer pass-through when the prescaler belongs to the watchdog
  a_r9_timer_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (psa && tmr_src) |=> tmr_tick);

  // R8: no timer tick without a source strobe
  a_r8_tick_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_src |=> !tmr_tick);
endmodule

bind wdt_shared_prescaler wdt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tmr_src    (tmr_src),
  .wdt_en     (wdt_en),
  .psa        (psa),
  .clrwdt     (clrwdt),
  .sleep_enter(sleep_enter),
  .asleep     (asleep),
  .rst_req    (rst_req),
  .wake_req   (wake_req),
  .to_n       (to_n),
  .tmr_tick   (tmr_tick)
);

// File: tb/wdt_shared_prescaler_tb.sv
module wdt_shared_prescaler_tb;
  localparam int BASE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wdt_tick = 1'b0;
  logic       tmr_src = 1'b0;
  logic       wdt_en = 1'b1;
  logic       psa = 1'b0;
  logic [2:0] ps = 3'd0;
  logic       clrwdt = 1'b0;
  logic       sleep_enter = 1'b0;
  logic       asleep = 1'b0;
  logic       rst_req, wake_req, to_n, tmr_tick;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  wdt_shared_prescaler #(.BASE_TICKS(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .tmr_src(tmr_src),
    .wdt_en(wdt_en), .psa(psa), .ps(ps), .clrwdt(clrwdt),
    .sleep_enter(sleep_enter), .asleep(asleep), .rst_req(rst_req),
    .wake_req(wake_req), .to_n(to_n), .tmr_tick(tmr_tick)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe_clr(input bit via_sleep);
    @(negedge clk);
    if (via_sleep) sleep_enter = 1'b1;
    else           clrwdt = 1'b1;
    @(negedge clk);
    sleep_enter = 1'b0;
    clrwdt = 1'b0;
  endtask

  // n watchdog ticks, two cycles each; events sampled in the cycle after each tick
  task automatic tick_scan(input int n, output int first, output int nrst,
                           output int nwake, output int second);
    first = 0; second = 0; nrst = 0; nwake = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      wdt_tick = 1'b1;
      @(negedge clk);
      wdt_tick = 1'b0;
      if (rst_req || wake_req) begin
        if (first == 0) first = i;
        else if (second == 0) second = i;
      end
      if (rst_req) nrst++;
      if (wake_req) nwake++;
    end
  endtask

  task automatic tmr_scan(input int n, output int first, output int cnt);
    first = 0; cnt = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      tmr_src = 1'b1;
      @(negedge clk);
      tmr_src = 1'b0;
      if (tmr_tick) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic t_reset_state();
    chk("R1 rst_req", int'(rst_req), 0);
    chk("R1 wake_req", int'(wake_req), 0);
    chk("R1 to_n", int'(to_n), 1);
    chk("R1 tmr_tick", int'(tmr_tick), 0);
  endtask

  task automatic t_base_timeout();
    int f, nr, nw, s;
    psa = 1'b0; wdt_en = 1'b1; asleep = 1'b0;
    strobe_clr(1'b0);
    tick_scan(20, f, nr, nw, s);
    chk("R2 first timeout tick", f, BASE);
    chk("R2 reset pulses", nr, 2);
    chk("R2 no wake", nw, 0);
    chk("R10 second timeout tick", s, 2 * BASE);
    chk("R5 flag low after timeout", int'(to_n), 0);
    strobe_clr(1'b0);
    chk("R5 flag restored by clear", int'(to_n), 1);
  endtask

  task automatic t_postscale(input int n);
    int f, nr, nw, s;
    psa = 1'b1; ps = 3'(n);
    strobe_clr(1'b0);
    tick_scan(BASE * (1 << n) + 2, f, nr, nw, s);
    chk($sformatf("R3 timeout tick ps=%0d", n), f, BASE * (1 << n));
    chk($sformatf("R3 reset kind ps=%0d", n), nr, 1);
  endtask

  task automatic t_sleep_wake();
    int f, nr, nw, s;
    psa = 1'b0;
    strobe_clr(1'b1);
    asleep = 1'b1;
    chk("R5 flag set by sleep strobe", int'(to_n), 1);
    tick_scan(BASE + 2, f, nr, nw, s);
    chk("R4 wake tick", f, BASE);
    chk("R4 wake pulses", nw, 1);
    chk("R4 no reset in sleep", nr, 0);
    asleep = 1'b0;
  endtask

  task automatic t_clear_restart();
    int f, nr, nw, s;
    psa = 1'b0;
    strobe_clr(1'b0);
    tick_scan(BASE - 1, f, nr, nw, s);
    chk("R6 no early timeout", f, 0);
    @(negedge clk);
    wdt_tick = 1'b1; clrwdt = 1'b1;
    @(negedge clk);
    wdt_tick = 1'b0; clrwdt = 1'b0;
    chk("R6 coincident clear blocks reset", int'(rst_req), 0);
    tick_scan(BASE + 2, f, nr, nw, s);
    chk("R6 restart after coincident clear", f, BASE);
    // prescaler zeroing when it serves the watchdog (ratio 1:2)
    psa = 1'b1; ps = 3'd1;
    strobe_clr(1'b0);
    tick_scan(BASE + 4, f, nr, nw, s);
    chk("R6 half-way no timeout", f, 0);
    strobe_clr(1'b0);
    tick_scan(2 * BASE + 2, f, nr, nw, s);
    chk("R6 prescaler cleared by strobe", f, 2 * BASE);
  endtask

  task automatic t_disabled();
    int f, nr, nw, s;
    psa = 1'b0;
    strobe_clr(1'b0);
    wdt_en = 1'b0;
    tick_scan(5 * BASE, f, nr, nw, s);
    chk("R7 no event when disabled", nr + nw, 0);
    chk("R7 flag stays high", int'(to_n), 1);
    wdt_en = 1'b1;
  endtask

  task automatic t_timer_div(input int n);
    int f, c;
    int div;
    div = 1 << (n + 1);
    psa = 1'b0; ps = 3'(n);
    do_reset();
    tmr_scan(2 * div, f, c);
    chk($sformatf("R8 first tick ps=%0d", n), f, div);
    chk($sformatf("R8 tick count ps=%0d", n), c, 2);
  endtask

  task automatic t_timer_pass();
    int f, c;
    psa = 1'b1; ps = 3'd5;
    tmr_scan(5, f, c);
    chk("R9 first passthrough", f, 1);
    chk("R9 passthrough count", c, 5);
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_reset_state();
        t_base_timeout();
        t_postscale(0);
        t_postscale(2);
        t_postscale(7);
        t_sleep_wake();
        t_clear_restart();
        t_disabled();
        t_timer_div(0);
        t_timer_div(1);
        t_timer_div(7);
        t_timer_pass();
      end
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule